// File: doc/BRIEF.md
# Configuration Word Loader with Staging FIFO

The block accepts 32-bit configuration words on a simple memory-mapped write port and hands them, in arrival order, to a word-wide output port that feeds the devices being configured. Words are staged in a FIFO behind one write-only data address. Either the host CPU fills the FIFO, or an external DMA engine fills it in bursts of half the FIFO capacity when the block raises a request line.

Before a load, software programs the expected total byte count and then sets the enable bit. A running byte counter advances by four for each word the target accepts. The load stops and an interrupt is raised in either of two cases: the counter reaches the total, or an error is flagged. An error is either a write into a full FIFO or an error report from the targets. The interrupt stays pending until software writes zero to the control register. That write also drops all control bits and discards any words left in the FIFO. A separate control bit drives the targets' reset line, so software can pulse the targets back into the unconfigured state.

Top module: `cfg_loader`

## Requirements
- R1: After reset the control bits, counters and FIFO are cleared. `irq_o`, `dma_req_o`, `tgt_valid_o` and `tgt_reset_o` are low.
- R2: The registers sit at fixed offsets. Control is at 0x40, with bit 0 = enable, bit 1 = target reset and bit 2 = DMA mode. Status is at 0x44. FIFO capacity in bytes (FIFO_DEPTH*4) is at 0x48. FIFO occupancy in words is at 0x4C. Total byte count is at 0x50 and current byte count at 0x54. Words are written to the FIFO at 0x3000. Reads of any other address return zero.
- R3: `tgt_valid_o` presents the oldest FIFO word only when all of these hold: enabled, byte count not reached, no error, no pending interrupt. A word is consumed when `tgt_ready_i` is high, and the current byte count then grows by 4.
- R4: Once the current count equals the total, no further word is presented. `irq_o` rises one cycle later. A total of zero raises it right after enabling.
- R5: `dma_req_o` is high only while enable and DMA mode are set, the load is not stopped, and at least half the FIFO is free.
- R6: A write to the FIFO address while the FIFO is full is dropped and sets status bit 1. The interrupt then follows while enabled.
- R7: When `tgt_err_i` is high while enabled, status bit 2 is set. Word output stops the next cycle, and the interrupt follows.
- R8: Only a write of exactly zero to control clears a pending interrupt. That write also clears all control bits and empties the FIFO. A nonzero control write leaves the interrupt pending.
- R9: `tgt_reset_o` follows control bit 1 and changes only on a control write.
- R10: A control write that sets enable while the block is disabled clears the current byte count and both error flags.
- R11: Status bit 0 is high while the load is active. Bit 16 mirrors the pending interrupt, and bit 18 mirrors `tgt_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register or FIFO write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| dma_req_o | output | 1 | Request to the DMA engine for a half-FIFO burst |
| irq_o | output | 1 | Load finished or failed |
| tgt_data_o | output | 32 | Configuration word to the targets |
| tgt_valid_o | output | 1 | `tgt_data_o` holds a word |
| tgt_ready_i | input | 1 | Targets take the word this cycle |
| tgt_err_i | input | 1 | Targets report a configuration error |
| tgt_done_i | input | 1 | Targets report configuration complete |
| tgt_reset_o | output | 1 | Reset line to the targets |

## Verification
The bench goes after the stop boundary. A design that compares the count one word late pushes an extra word past the total, and that shows on `tgt_valid_o` and the counter. It overfills the FIFO to confirm the dropped word never appears, and that occupancy stays at capacity rather than wrapping to zero. It writes a nonzero control value while the interrupt is pending; a design that clears on any control write would lose the interrupt. It runs DMA bursts against stalling targets, so a request computed from used rather than free space would overrun the FIFO. It also restarts after a failure, so error flags or a byte count that survive the restart would stall the next load at once.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned OFF_CTRL   = 32'h0040;
  localparam int unsigned OFF_STAT   = 32'h0044;
  localparam int unsigned OFF_SIZE   = 32'h0048;
  localparam int unsigned OFF_USED   = 32'h004C;
  localparam int unsigned OFF_TOTAL  = 32'h0050;
  localparam int unsigned OFF_CUR    = 32'h0054;
  localparam int unsigned OFF_FIFO   = 32'h3000;

  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_RST_BIT = 1;
  localparam int unsigned CTL_DMA_BIT = 2;

  localparam int unsigned ST_BUSY_BIT = 0;
  localparam int unsigned ST_OVF_BIT  = 1;
  localparam int unsigned ST_TERR_BIT = 2;
  localparam int unsigned ST_IRQ_BIT  = 16;
  localparam int unsigned ST_DONE_BIT = 18;

  typedef struct packed {
    logic dma;
    logic rst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cfg_loader_fifo.sv
module cfg_loader_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 14,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [CW-1:0]     fifo_cnt_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  output logic              fifo_push_o,
  output logic              fifo_pop_o,
  output logic              fifo_flush_o,
  output logic              tgt_valid_o,
  input  logic              tgt_ready_i,
  input  logic              tgt_err_i,
  input  logic              tgt_done_i,
  output logic              tgt_reset_o,
  output logic              dma_req_o,
  output logic              irq_o
);
  localparam int unsigned HALF = DEPTH / 2;

  ctrl_t       ctrl_q;
  logic [31:0] total_q, cur_q;
  logic        ovf_q, terr_q, irq_q;
  logic        ctrl_wr, total_wr, fifo_wr, zero_wr, start, stop, any_err;
  logic [CW-1:0] free_words;
  logic [31:0] status;

  assign ctrl_wr  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign total_wr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_TOTAL));
  assign fifo_wr  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_FIFO));
  assign zero_wr  = ctrl_wr && (bus_wdata_i == '0);
  assign start    = ctrl_wr && bus_wdata_i[CTL_EN_BIT] && !ctrl_q.en;

  assign any_err    = ovf_q || terr_q;
  assign stop       = (cur_q == total_q) || any_err || irq_q;
  assign free_words = CW'(DEPTH) - fifo_cnt_i;

  assign tgt_valid_o  = ctrl_q.en && !stop && !fifo_empty_i;
  assign fifo_pop_o   = tgt_valid_o && tgt_ready_i;
  assign fifo_push_o  = fifo_wr && !fifo_full_i;
  assign fifo_flush_o = zero_wr;
  assign dma_req_o    = ctrl_q.en && ctrl_q.dma && !stop && (free_words >= CW'(HALF));
  assign tgt_reset_o  = ctrl_q.rst;
  assign irq_o        = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      total_q <= '0;
      cur_q   <= '0;
      ovf_q   <= 1'b0;
      terr_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (fifo_pop_o) cur_q <= cur_q + 32'd4;
      if (ctrl_q.en && tgt_err_i) terr_q <= 1'b1;
      if (fifo_wr && fifo_full_i) ovf_q <= 1'b1;
      if (ctrl_q.en && ((cur_q == total_q) || any_err)) irq_q <= 1'b1;
      if (total_wr) total_q <= bus_wdata_i;
      if (ctrl_wr) begin
        ctrl_q.en  <= bus_wdata_i[CTL_EN_BIT];
        ctrl_q.rst <= bus_wdata_i[CTL_RST_BIT];
        ctrl_q.dma <= bus_wdata_i[CTL_DMA_BIT];
        if (start) begin
          cur_q  <= '0;
          ovf_q  <= 1'b0;
          terr_q <= 1'b0;
        end
        if (zero_wr) irq_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status = '0;
    status[ST_BUSY_BIT] = ctrl_q.en && !stop;
    status[ST_OVF_BIT]  = ovf_q;
    status[ST_TERR_BIT] = terr_q;
    status[ST_IRQ_BIT]  = irq_q;
    status[ST_DONE_BIT] = tgt_done_i;
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(OFF_CTRL):  bus_rdata_o = {29'd0, ctrl_q};
      ADDR_W'(OFF_STAT):  bus_rdata_o = status;
      ADDR_W'(OFF_SIZE):  bus_rdata_o = 32'(DEPTH * 4);
      ADDR_W'(OFF_USED):  bus_rdata_o = 32'(fifo_cnt_i);
      ADDR_W'(OFF_TOTAL): bus_rdata_o = total_q;
      ADDR_W'(OFF_CUR):   bus_rdata_o = cur_q;
      default:            bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ADDR_W     = 14,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              dma_req_o,
  output logic              irq_o,
  output logic [31:0]       tgt_data_o,
  output logic              tgt_valid_o,
  input  logic              tgt_ready_i,
  input  logic              tgt_err_i,
  input  logic              tgt_done_i,
  output logic              tgt_reset_o
);
  logic [CW-1:0] fifo_cnt;
  logic          fifo_full, fifo_empty, fifo_push, fifo_pop, fifo_flush;

  cfg_loader_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) fifo_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (fifo_flush),
    .push_i      (fifo_push),
    .push_data_i (bus_wdata_i),
    .pop_i       (fifo_pop),
    .head_o      (tgt_data_o),
    .cnt_o       (fifo_cnt),
    .full_o      (fifo_full),
    .empty_o     (fifo_empty)
  );

  cfg_loader_ctrl #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .fifo_cnt_i   (fifo_cnt),
    .fifo_full_i  (fifo_full),
    .fifo_empty_i (fifo_empty),
    .fifo_push_o  (fifo_push),
    .fifo_pop_o   (fifo_pop),
    .fifo_flush_o (fifo_flush),
    .tgt_valid_o  (tgt_valid_o),
    .tgt_ready_i  (tgt_ready_i),
    .tgt_err_i    (tgt_err_i),
    .tgt_done_i   (tgt_done_i),
    .tgt_reset_o  (tgt_reset_o),
    .dma_req_o    (dma_req_o),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 14,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       tgt_data_o,
  input logic              tgt_valid_o,
  input logic              tgt_ready_i,
  input logic              tgt_err_i,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic              tgt_reset_o,
  input logic [CW-1:0]     fifo_cnt
);
  logic ctl_wr;
  assign ctl_wr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));

  // R3
  held_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o && !tgt_ready_i && !bus_we_i && !tgt_err_i) |=> (tgt_valid_o && $stable(tgt_data_o)));

  // R4
  no_word_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !tgt_valid_o);

  // R5
  dma_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (fifo_cnt <= CW'(DEPTH / 2)) && !irq_o);

  // R7
  err_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_err_i && tgt_valid_o) |=> !tgt_valid_o);

  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(ctl_wr && (bus_wdata_i == 32'd0)));

  // R9
  reset_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tgt_reset_o) |-> $past(ctl_wr));
endmodule

bind cfg_loader cfg_loader_chk #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .tgt_data_o  (tgt_data_o),
  .tgt_valid_o (tgt_valid_o),
  .tgt_ready_i (tgt_ready_i),
  .tgt_err_i   (tgt_err_i),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .tgt_reset_o (tgt_reset_o),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rdy = 1'b0, terr = 1'b0, tdone = 1'b0;
  logic [31:0] rdata, tdata;
  logic dma_req, irq, tvalid, treset;

  int errors = 0, checks = 0, cycn = 0, rdy_mode = 0;
  logic [31:0] last_rd;

  // reference state
  int unsigned q[$];
  bit m_en, m_rst, m_dma, m_ovf, m_terr, m_irq;
  logic [31:0] m_cur, m_tot;

  always #2 clk = ~clk;

  cfg_loader #(.FIFO_DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dma_req_o(dma_req), .irq_o(irq),
    .tgt_data_o(tdata), .tgt_valid_o(tvalid), .tgt_ready_i(rdy),
    .tgt_err_i(terr), .tgt_done_i(tdone), .tgt_reset_o(treset)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cycn);
    end
  endtask

  function automatic bit m_stop();
    return (m_cur == m_tot) || m_ovf || m_terr || m_irq;
  endfunction
  function automatic bit m_valid();
    return m_en && !m_stop() && (q.size() > 0);
  endfunction
  function automatic bit m_dreq();
    return m_en && m_dma && !m_stop() && ((DEPTH - q.size()) >= DEPTH / 2);
  endfunction
  function automatic logic [31:0] m_read(logic [ADDR_W-1:0] a);
    logic [31:0] s;
    case (a)
      14'h0040: return {29'd0, m_dma, m_rst, m_en};
      14'h0044: begin
        s = '0; s[0] = m_en && !m_stop(); s[1] = m_ovf; s[2] = m_terr;
        s[16] = m_irq; s[18] = tdone; return s;
      end
      14'h0048: return DEPTH * 4;
      14'h004C: return q.size();
      14'h0050: return m_tot;
      14'h0054: return m_cur;
      default:  return 32'd0;
    endcase
  endfunction
  function automatic string rd_tag(logic [ADDR_W-1:0] a);
    if (a == 14'h0044) return "R11 status";
    if (a == 14'h0054) return "R3 cur";
    return "R2 readback";
  endfunction

  task automatic model_step();
    bit pop, irq_set;
    pop = m_valid() && rdy;
    irq_set = m_en && ((m_cur == m_tot) || m_ovf || m_terr);
    if (pop) begin void'(q.pop_front()); m_cur += 4; end
    if (m_en && terr) m_terr = 1;
    if (we && addr == 14'h3000) begin
      if (q.size() + (pop ? 1 : 0) >= DEPTH) m_ovf = 1;
      else q.push_back(wdata);
    end
    if (irq_set) m_irq = 1;
    if (we && addr == 14'h0050) m_tot = wdata;
    if (we && addr == 14'h0040) begin
      if (wdata[0] && !m_en) begin m_cur = 0; m_ovf = 0; m_terr = 0; end
      m_en = wdata[0]; m_rst = wdata[1]; m_dma = wdata[2];
      if (wdata == 0) begin m_irq = 0; q.delete(); end
    end
  endtask

  // inputs are set at the falling edge; outputs compared 1 ns later
  task automatic cyc();
    case (rdy_mode)
      0: rdy = 1'b0;
      1: rdy = 1'b1;
      default: rdy = (cycn % 3) != 0;
    endcase
    #1;
    chk("R4 irq", 32'(irq), 32'(m_irq));
    chk("R3 valid", 32'(tvalid), 32'(m_valid()));
    if (m_valid()) chk("R3 data order", tdata, q[0]);
    chk("R5 dma_req", 32'(dma_req), 32'(m_dreq()));
    chk("R9 tgt_reset", 32'(treset), 32'(m_rst));
    chk(rd_tag(addr), rdata, m_read(addr));
    last_rd = rdata;
    model_step();
    cycn++;
    @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0; addr = 14'h0044; wdata = '0;
  endtask
  task automatic rd(logic [ADDR_W-1:0] a);
    addr = a; cyc(); addr = 14'h0044;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pushed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 valid", 32'(tvalid), 0);
    chk("R1 reset line", 32'(treset), 0);
    rd(14'h004C); chk("R1 used", last_rd, 0);
    rd(14'h0040); chk("R1 ctrl", last_rd, 0);
    rd(14'h0048); chk("R2 size", last_rd, DEPTH * 4);
    rd(14'h0100); chk("R2 unmapped", last_rd, 0);

    // host-driven load with stalling target
    rdy_mode = 2;
    wr(14'h0050, 32'd24);
    wr(14'h0040, 32'h1);
    for (int i = 0; i < 6; i++) wr(14'h3000, 32'hA000_0000 + i);
    idle(20);
    chk("R4 irq after count", 32'(irq), 1);
    rd(14'h0054); chk("R3 cur final", last_rd, 24);
    wr(14'h0040, 32'h0);
    chk("R8 irq cleared", 32'(irq), 0);

    // nonzero write keeps irq, reset bit drives line
    rdy_mode = 1;
    wr(14'h0050, 32'd8);
    wr(14'h0040, 32'h1);
    wr(14'h3000, 32'h1111_1111);
    wr(14'h3000, 32'h2222_2222);
    idle(4);
    wr(14'h0040, 32'h2);
    chk("R8 irq held", 32'(irq), 1);
    chk("R9 reset line", 32'(treset), 1);
    wr(14'h0040, 32'h0);
    chk("R9 reset low", 32'(treset), 0);
    chk("R8 irq zero", 32'(irq), 0);

    // DMA mode bursts
    rdy_mode = 2;
    wr(14'h0050, 32'd128);
    wr(14'h0040, 32'h5);
    chk("R5 dma_req start", 32'(dma_req), 1);
    pushed = 0;
    for (int g = 0; g < 2000 && !irq; g++) begin
      if (dma_req && pushed < 32) begin
        for (int b = 0; b < DEPTH / 2; b++) begin
          wr(14'h3000, 32'hD000_0000 + pushed);
          pushed++;
        end
      end else cyc();
    end
    chk("R4 dma irq", 32'(irq), 1);
    chk("R5 dma_req low", 32'(dma_req), 0);
    rd(14'h0054); chk("R3 dma cur", last_rd, 128);
    wr(14'h0040, 32'h0);

    // overflow
    rdy_mode = 0;
    wr(14'h0050, 32'd400);
    wr(14'h0040, 32'h1);
    for (int i = 0; i < DEPTH + 1; i++) wr(14'h3000, 32'hB000_0000 + i);
    idle(2);
    rd(14'h0044); chk("R6 overflow flag", 32'(last_rd[1]), 1);
    rd(14'h004C); chk("R6 used capped", last_rd, DEPTH);
    chk("R6 irq", 32'(irq), 1);
    wr(14'h0040, 32'h0);
    rd(14'h004C); chk("R8 flushed", last_rd, 0);
    wr(14'h0040, 32'h1);
    rd(14'h0044); chk("R10 errors cleared", 32'(last_rd[2:1]), 0);
    rd(14'h0054); chk("R10 cur cleared", last_rd, 0);
    chk("R11 busy", 32'(last_rd[0]), 0);
    rd(14'h0044); chk("R11 busy bit", 32'(last_rd[0]), 1);

    // target error
    for (int i = 0; i < 3; i++) wr(14'h3000, 32'hC000_0000 + i);
    terr = 1'b1; cyc(); terr = 1'b0;
    chk("R7 output stops", 32'(tvalid), 0);
    rd(14'h0044); chk("R7 error flag", 32'(last_rd[2]), 1);
    chk("R7 irq", 32'(irq), 1);
    wr(14'h0040, 32'h0);

    // done input and zero total
    tdone = 1'b1;
    rd(14'h0044); chk("R11 done bit", 32'(last_rd[18]), 1);
    tdone = 1'b0;
    wr(14'h0050, 32'd0);
    wr(14'h0040, 32'h1);
    idle(1);
    chk("R4 zero total irq", 32'(irq), 1);
    rd(14'h0044); chk("R11 irq bit", 32'(last_rd[16]), 1);
    wr(14'h0040, 32'h3);
    wr(14'h0040, 32'h0);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule